// File: doc/BRIEF.md
# Multithreaded Warp Scheduler

The block decides, on one multiprocessor, which resident warp gets to issue its next instruction. Each warp shows two plain status bits. A residency bit is high while the block that owns the warp is loaded. A readiness bit is high when every operand of the warp's next instruction is available. A warp with both bits high is eligible. At most one warp holds the issue slot at any time. A warp of 32 threads runs on 8 lanes, so one instruction keeps the slot for DISPATCH_CYCLES clocks (4 by default).

The scheduler picks the eligible warp that issued least recently. After reset no warp has issued yet, so the lowest index wins. It keeps that warp for the whole dispatch window. On the last cycle of the window it arbitrates again, so the next dispatch starts on the following clock with no switching gap. When no warp is eligible at an arbitration point, the slot goes idle. For every clock the slot sits idle, a saturating counter advances.

All pins are plain control and status signals. No data stream passes through the block, so there is no handshake and no back-pressure: an eligible warp that is not picked simply waits.

Top module: `warp_issue_sched`

## Requirements
- R1: While rst_n is low and on the first cycle after it, issue_strobe and dispatch_busy are 0, issue_warp is 0 and idle_count is 0.
- R2: An arbitration point is a cycle in which dispatch_busy is 0, or the last cycle of a dispatch. If some warp has warp_valid and warp_ready both 1 at an arbitration point, then issue_strobe is 1 in the next cycle for exactly one cycle, and dispatch_busy is 1 for DISPATCH_CYCLES consecutive cycles starting there.
- R3: The warp granted is the eligible warp whose last grant is oldest. Warps never granted since reset rank older than any granted warp, and among themselves the lower index ranks older. issue_warp gives the granted index (binary) and stays constant for the whole dispatch.
- R4: When an eligible warp exists on the last cycle of a dispatch, the next issue_strobe follows on the very next cycle, so that grants repeat every DISPATCH_CYCLES cycles with no idle cycle between them.
- R5: warp_valid and warp_ready are looked at only on arbitration points. Changes on the other dispatch cycles have no effect on issue_warp, issue_strobe or dispatch_busy.
- R6: A warp whose warp_valid is 0 at an arbitration point is not granted, even when its warp_ready is 1.
- R7: idle_count advances by one at every clock edge at which dispatch_busy was 0. It saturates at 2^IDLE_W-1.
- R8: A warp whose warp_ready is 0 at an arbitration point is not granted, even when its warp_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| warp_valid | input | NUM_WARPS | Per-warp residency bit |
| warp_ready | input | NUM_WARPS | Per-warp operands-ready bit |
| issue_strobe | output | 1 | One-cycle pulse on the first cycle of each dispatch |
| dispatch_busy | output | 1 | High during each cycle of a dispatch |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the warp holding the slot |
| idle_count | output | IDLE_W | Saturating count of idle slot cycles |

## Verification
The last cycle of a dispatch is also the next arbitration point. Two events therefore share one clock: the current warp finishes its window, and the eligibility vector is sampled for the next grant. The bench provokes this by changing readiness and residency on a pseudo-random schedule that often hits that cycle. It also lets the warp that just finished compete again. A behavioural model keeps a queue ordered by last grant and predicts every output on every clock. Any gap, any repeated grant or any wrong pick then shows up as a miscompare at the exact cycle where it happens.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  typedef enum logic {
    SLOT_FREE = 1'b0,
    SLOT_BUSY = 1'b1
  } slot_state_e;

endpackage

// File: rtl/wsched_age_arbiter.sv
module wsched_age_arbiter #(
  parameter int NUM_WARPS = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_WARPS-1:0]         eligible,
  input  logic                         take,
  output logic                         any_eligible,
  output logic [$clog2(NUM_WARPS)-1:0] win_idx
);
  localparam int IDX_W = $clog2(NUM_WARPS);

  // tri[i][j] (i<j): 1 when warp i was granted less recently than warp j
  logic [NUM_WARPS-1:0] tri_q [NUM_WARPS];
  logic [NUM_WARPS-1:0] older [NUM_WARPS];
  logic [NUM_WARPS-1:0] win;

  always_comb begin
    for (int i = 0; i < NUM_WARPS; i++) begin
      for (int j = 0; j < NUM_WARPS; j++) begin
        if (i == j)     older[i][j] = 1'b1;
        else if (i < j) older[i][j] = tri_q[i][j];
        else            older[i][j] = ~tri_q[j][i];
      end
    end
  end

  genvar gi, gj;
  generate
    for (gi = 0; gi < NUM_WARPS; gi++) begin : g_row
      logic [NUM_WARPS-1:0] beats;
      always_comb begin
        for (int j = 0; j < NUM_WARPS; j++)
          beats[j] = older[gi][j] | ~eligible[j];
      end
      assign win[gi] = eligible[gi] & (&beats);

      for (gj = 0; gj < NUM_WARPS; gj++) begin : g_col
        if (gi < gj) begin : g_upper
          always_ff @(posedge clk) begin
            if (!rst_n)
              tri_q[gi][gj] <= 1'b1;
            else if (take && win[gi])
              tri_q[gi][gj] <= 1'b0;
            else if (take && win[gj])
              tri_q[gi][gj] <= 1'b1;
          end
        end else begin : g_unused
          always_ff @(posedge clk) tri_q[gi][gj] <= 1'b0;
        end
      end
    end
  endgenerate

  assign any_eligible = |eligible;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_WARPS; i++)
      if (win[i]) win_idx = win_idx | IDX_W'(i);
  end

  // R3: the age order is total, so at most one warp wins
  a_r3_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  // R6 and R8: the encoded winner is an eligible warp whenever one exists
  a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    any_eligible |-> eligible[win_idx]);

  // R3: a nonempty eligible set always yields a winner
  a_r3_winner_exists: assert property (@(posedge clk) disable iff (!rst_n)
    any_eligible |-> (win != '0));

endmodule

// File: rtl/wsched_dispatch_timer.sv
module wsched_dispatch_timer
  import wsched_pkg::*;
#(
  parameter int DISPATCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic arb_en,
  output logic busy,
  output logic issue_strobe
);
  localparam int CW = (DISPATCH_CYCLES > 1) ? $clog2(DISPATCH_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DISPATCH_CYCLES - 1);

  slot_state_e   state;
  logic [CW-1:0] cnt;
  logic          last;

  assign last   = (state == SLOT_BUSY) && (cnt == LAST);
  assign arb_en = (state == SLOT_FREE) || last;
  assign busy   = (state == SLOT_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SLOT_FREE;
      cnt          <= '0;
      issue_strobe <= 1'b0;
    end else if (arb_en) begin
      cnt          <= '0;
      issue_strobe <= grant;
      state        <= grant ? SLOT_BUSY : SLOT_FREE;
    end else begin
      cnt          <= cnt + 1'b1;
      issue_strobe <= 1'b0;
    end
  end

  // R2: a dispatch starts while the slot is occupied
  a_r2_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    issue_strobe |-> busy);

  // R2: the slot only drops after a full window
  a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);

  generate
    if (DISPATCH_CYCLES > 1) begin : g_pulse
      // R2: the strobe lasts one cycle
      a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        issue_strobe |=> !issue_strobe);
    end
  endgenerate

endmodule

// File: rtl/wsched_idle_counter.sv
module wsched_idle_counter #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  output logic [IDLE_W-1:0] count
);
  localparam logic [IDLE_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (inc && count != MAXV)
      count <= count + 1'b1;
  end

  // R7: one step per idle cycle below saturation
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != MAXV) |=> count == $past(count) + 1'b1);

  // R7: no change without an idle cycle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc || count == MAXV) |=> $stable(count));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS       = 24,
  parameter int DISPATCH_CYCLES = 4,
  parameter int IDLE_W          = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_WARPS-1:0]         warp_valid,
  input  logic [NUM_WARPS-1:0]         warp_ready,
  output logic                         issue_strobe,
  output logic                         dispatch_busy,
  output logic [$clog2(NUM_WARPS)-1:0] issue_warp,
  output logic [IDLE_W-1:0]            idle_count
);
  localparam int IDX_W = $clog2(NUM_WARPS);

  logic [NUM_WARPS-1:0] eligible;
  logic                 any_eligible;
  logic [IDX_W-1:0]     win_idx;
  logic                 arb_en;
  logic                 take;

  assign eligible = warp_valid & warp_ready;
  assign take     = arb_en & any_eligible;

  wsched_age_arbiter #(.NUM_WARPS(NUM_WARPS)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .eligible     (eligible),
    .take         (take),
    .any_eligible (any_eligible),
    .win_idx      (win_idx)
  );

  wsched_dispatch_timer #(.DISPATCH_CYCLES(DISPATCH_CYCLES)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant        (take),
    .arb_en       (arb_en),
    .busy         (dispatch_busy),
    .issue_strobe (issue_strobe)
  );

  wsched_idle_counter #(.IDLE_W(IDLE_W)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (!dispatch_busy),
    .count (idle_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    issue_warp <= '0;
    else if (take) issue_warp <= win_idx;
  end

  // R2 and R4: any eligible warp at an arbitration point starts a dispatch next cycle
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && any_eligible) |=> issue_strobe);

  // R3: the granted index holds through the dispatch
  a_r3_hold_warp: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch_busy && !issue_strobe) |-> $stable(issue_warp));

  // R5: with no arbitration point, the slot does not change hands
  a_r5_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> !issue_strobe);

endmodule

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;
  localparam int N     = 24;
  localparam int D     = 4;
  localparam int IW    = 6;
  localparam int IMAX  = (1 << IW) - 1;
  localparam int XW    = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  warp_valid = '0;
  logic [N-1:0]  warp_ready = '0;
  logic          issue_strobe;
  logic          dispatch_busy;
  logic [XW-1:0] issue_warp;
  logic [IW-1:0] idle_count;

  always #10 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N), .DISPATCH_CYCLES(D), .IDLE_W(IW)) u_warp_issue_sched (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_ready(warp_ready),
    .issue_strobe(issue_strobe), .dispatch_busy(dispatch_busy),
    .issue_warp(issue_warp), .idle_count(idle_count)
  );

  // behavioural reference
  int    order[$];
  bit    m_busy, m_strobe;
  int    m_cnt, m_sel, m_idle;
  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic model_reset();
    order.delete();
    for (int i = 0; i < N; i++) order.push_back(i);
    m_busy = 0; m_strobe = 0; m_cnt = 0; m_sel = 0; m_idle = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit free;
      int pos;
      free = !m_busy || (m_cnt == D - 1);
      if (!m_busy && m_idle < IMAX) m_idle++;
      if (free) begin
        pos = -1;
        for (int k = 0; k < order.size(); k++)
          if (pos < 0 && warp_valid[order[k]] && warp_ready[order[k]]) pos = k;
        if (pos >= 0) begin
          m_sel = order[pos];
          order.delete(pos);
          order.push_back(m_sel);
          m_busy = 1; m_cnt = 0; m_strobe = 1;
        end else begin
          m_busy = 0; m_cnt = 0; m_strobe = 0;
        end
      end else begin
        m_cnt++;
        m_strobe = 0;
      end
    end
  end

  task automatic chk(string what, string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // sample away from the rising edge, then let the caller change inputs
  task automatic tick();
    @(negedge clk);
    chk("issue_strobe", cur_req, int'(issue_strobe), int'(m_strobe));
    chk("dispatch_busy", cur_req, int'(dispatch_busy), int'(m_busy));
    if (m_busy || cur_req == "R1") chk("issue_warp", cur_req, int'(issue_warp), m_sel);
    chk("idle_count", cur_req, int'(idle_count), m_idle);
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned nxt();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    // R1: reset state, during reset and just after release
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R2 R3 R4: every warp eligible, rotation by age, no gaps
    cur_req = "R3";
    warp_valid = '1; warp_ready = '1;
    repeat (N * D + 12) tick();

    // R4: a single ready warp reissues every D cycles
    cur_req = "R4";
    warp_ready = '0; warp_ready[5] = 1'b1;
    repeat (5 * D) tick();

    // R7: nothing eligible, idle count climbs to saturation
    cur_req = "R7";
    warp_ready = '0;
    repeat (IMAX + 10) tick();

    // R6: ready high on non-resident warps only for odd indices
    cur_req = "R6";
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    warp_ready = '1;
    for (int i = 0; i < N; i++) warp_valid[i] = (i % 2 == 0);
    repeat (4 * N) tick();

    // R8: resident warps that are not ready are never chosen
    cur_req = "R8";
    warp_valid = '1;
    for (int i = 0; i < N; i++) warp_ready[i] = (i % 3 == 1);
    repeat (4 * N) tick();

    // R5 and R2: inputs change on every cycle, including mid-window and last-cycle hits
    cur_req = "R5";
    for (int c = 0; c < 1500; c++) begin
      if (c % 37 == 0) warp_valid = N'(nxt()) | N'(nxt());
      warp_ready = N'(nxt()) & N'(nxt());
      tick();
    end

    // R2: sparse eligibility, mixing idle gaps with grants
    cur_req = "R2";
    for (int c = 0; c < 600; c++) begin
      warp_valid = N'(nxt());
      warp_ready = (nxt() % 4 == 0) ? N'(nxt()) : '0;
      tick();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule